// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

A single timer channel that counts down a 24-bit value at a rate set by an 8-bit prescaler driven from a reference clock enable. Software programs an initial count and a control word through a small word-addressed register port. It then starts, pauses, resumes or resets the count. On each expiry a sticky status flag is raised, and that flag drives a level interrupt when interrupts are enabled.

Two modes are available. In one-shot mode the channel stops after one expiry, reloads its initial count and clears its own enable. In periodic mode it reloads and keeps running. Clearing the enable freezes the count, so the time remaining to expiry is kept across a pause. Changing the prescaler while running changes only the rate of later decrements. A counter-reset request always beats an enable written in the same word.

Top module: `prescaled_timer`

Register map (word index on `addr_i`): 0 control, 1 initial count, 2 current count (read-only), 3 status. Control fields: bit 30 run enable, bit 29 interrupt enable, bit 27 mode (0 one-shot, 1 periodic), bit 26 counter reset (write-only, reads 0), bit 25 active (read-only), bits 7:0 prescale. All other control bits read 0. Status bit 0 is the expiry flag.

## Requirements
- R1: After reset the control register reads 0x0000_0005 (prescale 5, all else 0). The initial count, current count and status registers read 0, and `irq_o` is low.
- R2: The control register stores interrupt enable (bit 29), mode (bit 27) and prescale (bits 7:0) as written. Bit 25 reads the same value as the run enable (bit 30). Bits 31, 28, 26 and 24:8 always read 0.
- R3: A control write with bit 26 set clears run enable and active, zeroes the current count and leaves the status flag unchanged, even when bit 30 is set in the same write.
- R4: Setting bit 30 from the stopped state with a current count of 0 and a nonzero initial count N loads N into the current count, visible on the cycle after the write. Expiry happens on exactly the N×(P+1)-th `tick_i` pulse after that write, where P is the prescale. The prescaler phase restarts on every start or resume.
- R5: On a one-shot expiry, run enable and active clear, the current count reloads the initial count and the status flag sets. No further expiry occurs while the channel is stopped.
- R6: On a periodic expiry the current count reloads the initial count, run enable stays set and the status flag sets once per period.
- R7: Clearing bit 30 while running freezes the current count against `tick_i`. Setting bit 30 again with a nonzero current count resumes from the frozen value, and expiry follows after count×(P+1) further ticks.
- R8: Rewriting the prescale field while running leaves the current count unchanged. Later decrements use the new prescale.
- R9: Setting bit 30 from the stopped state while both the current count and the initial count are 0 sets the status flag on the next cycle and leaves run enable at 0.
- R10: Writing status bit 0 as 1 clears the flag and writing it as 0 has no effect. An expiry in the same cycle as a clearing write leaves the flag set.
- R11: `irq_o` is high exactly when the status flag and interrupt enable are both 1. The flag still sets when interrupts are disabled.
- R12: A write to the initial count register does not disturb a running current count, and the value is used at the next reload. Writes to the current count register are ignored. Initial counts up to 2^24−1 are held and loaded exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Reference clock enable, one pulse per reference tick |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word index (0 control, 1 initial, 2 current, 3 status) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the register selected by `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that `tick_i` and `wr_en_i` are single-cycle synchronous strobes with no unknown values after reset. They also assume that only one register is written per cycle, which the single address port enforces. The random stimulus draws small prescale and count values so that expiries, reloads, zero-count starts and write/expiry collisions happen often. Counter resets are drawn rarely, so that runs last long enough to reach expiry. A separate ps 255 case covers the widest prescaler span.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_INIT = 2'd1;
  localparam logic [1:0] A_CURR = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam int B_EN   = 30;
  localparam int B_IE   = 29;
  localparam int B_MODE = 27;
  localparam int B_CRST = 26;
  localparam int B_ACT  = 25;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PS_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            run_i,
  input  logic            tick_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            step_o
);
  logic [PS_W-1:0] pre_q;
  logic            wrap;

  // >= so a prescale lowered below the current phase still wraps
  assign wrap   = pre_q >= ps_i;
  assign step_o = run_i & tick_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (restart_i)         pre_q <= '0;
    else if (run_i && tick_i)   pre_q <= wrap ? '0 : pre_q + 1'b1;
  end

  assert_phase_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !step_o || ps_i == '0);
endmodule

// File: rtl/tmr_down.sv
module tmr_down #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = step_i & (cnt_q <= CNT_W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (load_i)   cnt_q <= init_i;
    else if (step_i)   cnt_q <= expire_o ? init_i : cnt_q - 1'b1;
  end

  assert_count_dec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !clear_i && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !clear_i && !load_i) |=> cnt_q == $past(init_i));
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PS_W   = 8,
  parameter int PS_RST = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic             en_q, ie_q, mode_q, flag_q;
  logic [PS_W-1:0]  ps_q;
  logic [CNT_W-1:0] init_q, cnt;
  logic             ctrl_wr, init_wr, stat_wr;
  logic             w_en, w_crst;
  logic             run, start_req, fresh, zero_start, load, clear, restart;
  logic             step, expire, flag_set;
  logic             en_n;
  logic [DATA_W-1:0] ctrl_rd;

  assign ctrl_wr = wr_en_i && addr_i == A_CTRL;
  assign init_wr = wr_en_i && addr_i == A_INIT;
  assign stat_wr = wr_en_i && addr_i == A_STAT;
  assign w_en    = wdata_i[B_EN];
  assign w_crst  = wdata_i[B_CRST];

  // a write that stops or resets the channel preempts this cycle's tick
  assign run        = en_q & ~(ctrl_wr & (~w_en | w_crst));
  assign start_req  = ctrl_wr & ~w_crst & w_en & ~en_q;
  assign fresh      = start_req & (cnt == '0);
  assign zero_start = fresh & (init_q == '0);
  assign load       = fresh & (init_q != '0);
  assign clear      = ctrl_wr & w_crst;
  assign restart    = start_req | clear;
  assign flag_set   = expire | zero_start;

  tmr_prescale #(.PS_W(PS_W)) u_pre (
    .clk_i, .rst_ni,
    .restart_i (restart),
    .run_i     (run),
    .tick_i,
    .ps_i      (ps_q),
    .step_o    (step)
  );

  tmr_down #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .step_i   (step),
    .load_i   (load),
    .clear_i  (clear),
    .init_i   (init_q),
    .cnt_o    (cnt),
    .expire_o (expire)
  );

  always_comb begin
    en_n = en_q;
    if (ctrl_wr) begin
      if (w_crst)         en_n = 1'b0;
      else if (start_req) en_n = ~zero_start;
      else if (!w_en)     en_n = 1'b0;
    end
    if (expire && !mode_q) en_n = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      mode_q <= 1'b0;
      ps_q   <= PS_W'(PS_RST);
      init_q <= '0;
      flag_q <= 1'b0;
    end else begin
      en_q <= en_n;
      if (ctrl_wr) begin
        ie_q   <= wdata_i[B_IE];
        mode_q <= wdata_i[B_MODE];
        ps_q   <= wdata_i[PS_W-1:0];
      end
      if (init_wr) init_q <= wdata_i[CNT_W-1:0];
      if (flag_set)                    flag_q <= 1'b1;
      else if (stat_wr && wdata_i[0])  flag_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_rd            = '0;
    ctrl_rd[PS_W-1:0]  = ps_q;
    ctrl_rd[B_EN]      = en_q;
    ctrl_rd[B_ACT]     = en_q;
    ctrl_rd[B_IE]      = ie_q;
    ctrl_rd[B_MODE]    = mode_q;
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = ctrl_rd;
      A_INIT:  rdata_o = {{PAD_W{1'b0}}, init_q};
      A_CURR:  rdata_o = {{PAD_W{1'b0}}, cnt};
      default: rdata_o = {{(DATA_W-1){1'b0}}, flag_q};
    endcase
  end

  assign irq_o = flag_q & ie_q;

  assert_crst_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear |=> !en_q && cnt == '0 && flag_q == $past(flag_q));
  assert_oneshot_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !mode_q) |=> !en_q && flag_q);
  assert_periodic_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && mode_q) |=> en_q && flag_q);
  assert_pause_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !ctrl_wr) |=> $stable(cnt));
  assert_ps_no_touch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && en_q && w_en && !w_crst && !step) |=> cnt == $past(cnt));
  assert_zero_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_start |=> flag_q && !en_q);
  assert_w1c_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && wdata_i[0] && !flag_set) |=> !flag_q);
endmodule

// File: tb/tb_prescaled_timer.sv
module tb_prescaled_timer;
  localparam logic [31:0] EN   = 32'h4000_0000;
  localparam logic [31:0] IE   = 32'h2000_0000;
  localparam logic [31:0] PER  = 32'h0800_0000;
  localparam logic [31:0] CRST = 32'h0400_0000;
  localparam logic [31:0] ACT  = 32'h0200_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int nchk = 0, nbad = 0;
  bit done = 0;

  prescaled_timer dut (.*);

  always #5 clk_i = ~clk_i;

  // requirement-level model
  bit        m_en, m_ie, m_mode, m_flag;
  bit [7:0]  m_ps, m_pre;
  bit [23:0] m_init, m_cnt;

  task automatic model_reset();
    m_en = 0; m_ie = 0; m_mode = 0; m_flag = 0;
    m_ps = 8'd5; m_pre = 0; m_init = 0; m_cnt = 0;
  endtask

  task automatic model_step(bit w, bit [1:0] a, bit [31:0] d, bit t);
    bit cw, run, exp_ev, zs;
    bit [23:0] nc;
    bit [7:0] np;
    bit ne;
    cw = w && a == 2'd0;
    run = m_en && !(cw && (!d[30] || d[26]));
    nc = m_cnt; np = m_pre; ne = m_en; exp_ev = 0; zs = 0;
    if (run && t) begin
      if (m_pre >= m_ps) begin
        np = 0;
        if (m_cnt <= 1) begin exp_ev = 1; nc = m_init; end
        else nc = m_cnt - 1;
      end else np = m_pre + 1;
    end
    if (cw) begin
      if (d[26]) begin ne = 0; nc = 0; np = 0; end
      else if (d[30] && !m_en) begin
        np = 0;
        if (m_cnt == 0 && m_init == 0) begin zs = 1; ne = 0; end
        else begin ne = 1; if (m_cnt == 0) nc = m_init; end
      end else if (!d[30]) ne = 0;
      m_ie = d[29]; m_mode_next(d[27]);
    end
    if (exp_ev && !m_mode_old) ne = 0;
    if (exp_ev || zs) m_flag = 1;
    else if (w && a == 2'd3 && d[0]) m_flag = 0;
    if (cw) m_ps = d[7:0];
    if (w && a == 2'd1) m_init = d[23:0];
    m_en = ne; m_cnt = nc; m_pre = np;
    m_mode_commit();
  endtask

  bit m_mode_old, m_mode_pend, m_mode_has;
  task automatic m_mode_next(bit v); m_mode_pend = v; m_mode_has = 1; endtask
  task automatic m_mode_commit();
    if (m_mode_has) m_mode = m_mode_pend;
    m_mode_has = 0;
    m_mode_old = m_mode;
  endtask

  function automatic bit [31:0] exp_read(bit [1:0] a);
    case (a)
      2'd0: return {1'b0, m_en, m_ie, 1'b0, m_mode, 1'b0, m_en, 17'd0, m_ps};
      2'd1: return {8'd0, m_init};
      2'd2: return {8'd0, m_cnt};
      default: return {31'd0, m_flag};
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit w, bit [1:0] a, bit [31:0] d, bit t);
    wr_en_i = w; addr_i = a; wdata_i = d; tick_i = t;
    @(posedge clk_i);
    model_step(w, a, d, t);
    @(negedge clk_i);
    wr_en_i = 0; tick_i = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(0, 2'd0, 0, 1);
  endtask

  task automatic rd(bit [1:0] a, output logic [31:0] v);
    wr_en_i = 0; addr_i = a; #1; v = rdata_o;
  endtask

  task automatic clean();
    cyc(1, 2'd0, CRST | 32'd5, 0);
    cyc(1, 2'd3, 32'd1, 0);
  endtask

  logic [31:0] v;

  initial begin
    model_reset(); m_mode_old = 0; m_mode_has = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 32'h5);
    rd(1, v); chk("R1 init", v, 0);
    rd(2, v); chk("R1 curr", v, 0);
    rd(3, v); chk("R1 stat", v, 0);
    chk("R1 irq", irq_o, 0);

    // R2 field storage and reserved bits
    cyc(1, 2'd0, 32'hB8FF_FF3C, 0);
    rd(0, v); chk("R2 ctrl fields", v, 32'h2800_003C);

    // R9 zero-count start fires at once
    clean(); cyc(1, 2'd1, 0, 0);
    cyc(1, 2'd0, EN | 32'd5, 0);
    rd(3, v); chk("R9 flag", v, 1);
    rd(0, v); chk("R9 ctrl", v, 32'h5);
    chk("R11 irq masked", irq_o, 0);

    // R4 exact expiry N=3 P=2, R5 one-shot stop
    clean(); cyc(1, 2'd1, 3, 0);
    cyc(1, 2'd0, EN | 32'd2, 0);
    rd(0, v); chk("R4 ctrl active", v, EN | ACT | 32'd2);
    rd(2, v); chk("R4 curr loaded", v, 3);
    ticks(8);
    rd(3, v); chk("R4 no early expiry", v, 0);
    rd(2, v); chk("R4 curr mid", v, 1);
    ticks(1);
    rd(3, v); chk("R4 expiry", v, 1);
    rd(2, v); chk("R5 reload", v, 3);
    rd(0, v); chk("R5 self clear", v, 32'd2);
    cyc(1, 2'd3, 1, 0);
    ticks(20);
    rd(3, v); chk("R5 no second expiry", v, 0);

    // R4 widest prescale
    clean(); cyc(1, 2'd1, 2, 0);
    cyc(1, 2'd0, EN | 32'd255, 0);
    ticks(511);
    rd(3, v); chk("R4 ps255 before", v, 0);
    ticks(1);
    rd(3, v); chk("R4 ps255 at", v, 1);

    // R6 periodic, R11 irq
    clean(); cyc(1, 2'd1, 2, 0);
    cyc(1, 2'd0, EN | PER | 32'd1, 0);
    ticks(4);
    rd(3, v); chk("R6 first period", v, 1);
    rd(0, v); chk("R6 still enabled", v, EN | ACT | PER | 32'd1);
    rd(2, v); chk("R6 reload", v, 2);
    chk("R11 irq off when ie=0", irq_o, 0);
    cyc(1, 2'd0, EN | PER | IE | 32'd1, 0);
    chk("R11 irq on", irq_o, 1);
    cyc(1, 2'd3, 1, 0);
    chk("R11 irq cleared", irq_o, 0);
    ticks(3);
    rd(3, v); chk("R6 mid period", v, 0);
    ticks(1);
    rd(3, v); chk("R6 second period", v, 1);
    chk("R11 irq second", irq_o, 1);

    // R10 W1C and set-wins
    clean(); cyc(1, 2'd1, 1, 0);
    cyc(1, 2'd0, EN | PER | 32'd0, 0);
    ticks(1);
    cyc(1, 2'd3, 1, 1);
    rd(3, v); chk("R10 set wins", v, 1);
    cyc(1, 2'd3, 0, 0);
    rd(3, v); chk("R10 write0 ignored", v, 1);
    cyc(1, 2'd3, 1, 0);
    rd(3, v); chk("R10 clear", v, 0);

    // R7 pause and resume
    clean(); cyc(1, 2'd1, 4, 0);
    cyc(1, 2'd0, EN | 32'd1, 0);
    ticks(4);
    cyc(1, 2'd0, 32'd1, 0);
    rd(2, v); chk("R7 frozen", v, 2);
    ticks(10);
    rd(2, v); chk("R7 still frozen", v, 2);
    rd(3, v); chk("R7 no flag paused", v, 0);
    cyc(1, 2'd0, EN | 32'd1, 0);
    rd(2, v); chk("R7 resume value", v, 2);
    ticks(3);
    rd(3, v); chk("R7 before expiry", v, 0);
    ticks(1);
    rd(3, v); chk("R7 expiry", v, 1);

    // R8 prescale change
    clean(); cyc(1, 2'd1, 4, 0);
    cyc(1, 2'd0, EN | 32'd3, 0);
    ticks(4);
    rd(2, v); chk("R8 before change", v, 3);
    cyc(1, 2'd0, EN | 32'd0, 0);
    rd(2, v); chk("R8 count kept", v, 3);
    ticks(2);
    rd(2, v); chk("R8 new rate", v, 1);
    ticks(1);
    rd(3, v); chk("R8 expiry", v, 1);

    // R3 reset beats enable
    clean(); cyc(1, 2'd1, 4, 0);
    cyc(1, 2'd0, EN | 32'd5, 0);
    ticks(3);
    cyc(1, 2'd0, EN | CRST | 32'd5, 0);
    rd(0, v); chk("R3 ctrl", v, 32'h5);
    rd(2, v); chk("R3 curr", v, 0);
    rd(3, v); chk("R3 no flag", v, 0);

    // R12 init write while running, curr read-only, max count
    clean(); cyc(1, 2'd1, 6, 0);
    cyc(1, 2'd0, EN | 32'd0, 0);
    ticks(2);
    cyc(1, 2'd1, 9, 0);
    rd(2, v); chk("R12 curr undisturbed", v, 4);
    cyc(1, 2'd2, 32'h77, 0);
    rd(2, v); chk("R12 curr read-only", v, 4);
    ticks(4);
    rd(2, v); chk("R12 new reload", v, 9);
    clean(); cyc(1, 2'd1, 32'h00FF_FFFF, 0);
    rd(1, v); chk("R12 max init", v, 32'h00FF_FFFF);
    cyc(1, 2'd0, EN | 32'd0, 0);
    rd(2, v); chk("R12 max loaded", v, 32'h00FF_FFFF);
    ticks(1);
    rd(2, v); chk("R12 max dec", v, 32'h00FF_FFFE);

    // random mix against model
    void'($urandom(32'd1234));
    clean();
    for (int i = 0; i < 4000; i++) begin
      bit w, t;
      bit [1:0] a;
      bit [31:0] d;
      w = ($urandom % 4) == 0;
      t = $urandom % 2;
      a = $urandom % 4;
      d = $urandom;
      case (a)
        2'd0: begin
          d[7:0] = $urandom % 4;
          d[26] = ($urandom % 16) == 0;
          d[30] = ($urandom % 4) != 0;
        end
        2'd1: d = $urandom % 7;
        default: ;
      endcase
      addr_i = $urandom % 4; #1;
      chk("R4 R5 R6 R7 random read", rdata_o, exp_read(addr_i));
      chk("R11 random irq", irq_o, m_flag & m_ie);
      cyc(w, a, d, t);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule